// File: doc/BRIEF.md
# Banked Configuration and Event Register File for an Eight-Channel Line Interface

This block holds the host-visible configuration and event status for an eight-channel line interface. The host reaches it over a synchronous bus with a 5-bit address, an 8-bit data path and one-cycle read and write strobes. The 5-bit space is too small for every register, so a bank pointer at the top address (1Fh) picks which of four banks the lower addresses reach. That pointer is present at 1Fh whatever bank is selected. The four banks are primary, secondary, per-channel and test.

Each channel has an event input. An event latches a sticky status bit, and a mask register gates each bit onto an active-high interrupt output. A control bit picks how the host clears status. In clear-on-read mode, reading the status register clears every bit. In clear-on-write mode, writing a 1 to a bit clears that bit. When a new event arrives in the same cycle as a clear, the event wins. The per-channel bank drives one control bit per channel to the datapath for each of these functions: jitter attenuator enable, deep FIFO select, FIFO limit trip, short-circuit protection off, alarm insertion on signal loss, receive clock invert and transmit clock invert.

Top module: `lif_cfg_regfile`

## Requirements
- R1: When synchronous active-low reset is held at a clock edge, every register becomes 00h except the event mask, which becomes FFh. Read data becomes 00h and the interrupt output goes low.
- R2: Address 1Fh is the bank pointer under every pointer value, including undefined ones. It reads back the last byte written to it.
- R3: The pointer code picks the bank: 00h primary, AAh secondary, 01h per-channel, 02h test. Plain read/write storage sits at primary 00h–13h, secondary 00h–06h, per-channel 00h–07h and test 00h–07h. Each bank holds its own contents.
- R4: Reads of reserved addresses return 00h, and writes to them change nothing. Under any undefined pointer value, every address other than 1Fh is reserved.
- R5: Per-channel bank words drive the channel control outputs, with bit n controlling channel n. The word-to-output map is 00h attenuator enable, 01h deep FIFO, 02h limit trip, 03h short-protect off, 04h alarm on loss, 05h receive clock invert, 06h transmit clock invert.
- R6: A read strobe at one clock edge puts the addressed value on read data after that same edge. Read data then holds until the next read.
- R7: An event bit high at an edge sets status bit n in the primary bank at 14h. The bit stays set until the host clears it.
- R8: With control bit 0 clear (per-channel bank, 1Eh), a read of 14h returns the status and clears all of it in the same edge. Writes to 14h are ignored in this mode.
- R9: With control bit 0 set, writing to 14h clears each status bit whose data bit is 1. Reads of 14h do not clear status in this mode.
- R10: An event arriving in the same cycle as a clear of that bit leaves the bit set.
- R11: The interrupt output is high exactly when some status bit is set and its mask bit (primary 15h, 1 = masked) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 5 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| chan_evt | input | 8 | Per-channel event pulses |
| irq | output | 1 | Interrupt, active high |
| ja_en | output | 8 | Jitter attenuator enable per channel |
| ja_deep | output | 8 | Deep FIFO (128-bit) select per channel |
| ja_trip | output | 8 | FIFO limit trip enable per channel |
| scp_off | output | 8 | Short-circuit protection disable per channel |
| ais_on_los | output | 8 | Alarm insertion on signal loss per channel |
| rclk_inv | output | 8 | Receive clock invert per channel |
| tclk_inv | output | 8 | Transmit clock invert per channel |

## Verification
Read data is due right after the edge that samples the read strobe. Status, mask, pointer and control-output changes also show after the edge that samples the write or event, because the interrupt output is combinational from the status and mask registers. The bench drives every stimulus at a falling edge and lets exactly one rising edge pass. It then samples read data, interrupt and channel outputs at the next falling edge, against a model advanced once for that same edge. The model computes the expected read value from its state before the edge, so clear-on-read and event collisions are predicted in the cycle they occur.

// File: rtl/lif_cfg_pkg.sv
// Package: shared constants and decode type for the banked register file.
// Assumes an 8-bit data path and 5-bit address; bank codes are sparse bytes.
package lif_cfg_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    // Pointer codes for each bank
    localparam logic [DATA_W-1:0] PTR_PRI = 8'h00;
    localparam logic [DATA_W-1:0] PTR_SEC = 8'hAA;
    localparam logic [DATA_W-1:0] PTR_CHN = 8'h01;
    localparam logic [DATA_W-1:0] PTR_TST = 8'h02;

    // Fixed addresses
    localparam logic [ADDR_W-1:0] A_PTR  = 5'h1F;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h14;
    localparam logic [ADDR_W-1:0] A_MASK = 5'h15;
    localparam logic [ADDR_W-1:0] A_ICTL = 5'h1E;

    // Storage depth per bank, and their base in the flat store
    localparam int PRI_N = 20;
    localparam int SEC_N = 7;
    localparam int CHN_N = 8;
    localparam int TST_N = 8;
    localparam int PRI_B = 0;
    localparam int SEC_B = PRI_B + PRI_N;
    localparam int CHN_B = SEC_B + SEC_N;
    localparam int TST_B = CHN_B + CHN_N;
    localparam int STORE_N = TST_B + TST_N;
    localparam int IDX_W = $clog2(STORE_N);

    // Decoded access target
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             hit_store;
        logic             is_ptr;
        logic             is_stat;
        logic             is_mask;
        logic             is_ictl;
    } dec_t;
endpackage

// File: rtl/lif_cfg_decode.sv
// Module: address decoder. Maps (pointer, address) to a flat storage index or
// to one of the special registers. Purely combinational; unknown pointer codes
// leave only the pointer itself reachable.
module lif_cfg_decode
    import lif_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ptr,
    output dec_t              dec
);
    // Return a flat store hit if the address falls inside the bank depth
    function automatic dec_t store_hit(input logic [ADDR_W-1:0] a, input int base, input int depth);
        dec_t r;
        r = '0;
        if (int'(a) < depth) begin
            r.hit_store = 1'b1;
            r.idx       = IDX_W'(base + int'(a));
        end
        return r;
    endfunction

    // Decode the access target for the current pointer
    always_comb begin
        dec = '0;
        if (addr == A_PTR) begin
            dec.is_ptr = 1'b1;
        end else begin
            case (ptr)
                PTR_PRI: begin
                    dec = store_hit(addr, PRI_B, PRI_N);
                    if (addr == A_STAT) dec.is_stat = 1'b1;
                    if (addr == A_MASK) dec.is_mask = 1'b1;
                end
                PTR_SEC: dec = store_hit(addr, SEC_B, SEC_N);
                PTR_CHN: begin
                    dec = store_hit(addr, CHN_B, CHN_N);
                    if (addr == A_ICTL) dec.is_ictl = 1'b1;
                end
                PTR_TST: dec = store_hit(addr, TST_B, TST_N);
                default: dec = '0;
            endcase
        end
    end

    // Pointer address always decodes to the pointer (R2)
    always_comb begin
        p_ptr_everywhere_r2: assert (!(addr == A_PTR) || (dec.is_ptr && !dec.hit_store));
    end
    // At most one target is selected
    always_comb begin
        p_single_target_r3: assert ($countones({dec.hit_store, dec.is_ptr, dec.is_stat,
                                                 dec.is_mask, dec.is_ictl}) <= 1);
    end
endmodule

// File: rtl/lif_cfg_store.sv
// Module: flat byte store for all plain read/write registers of every bank.
// Assumes one write port and one combinational read port; a parameterised
// window of words is exported as taps for datapath controls.
module lif_cfg_store #(
    parameter int DEPTH  = 43,
    parameter int DW     = 8,
    parameter int IW     = 6,
    parameter int TAP_B  = 27,
    parameter int TAP_N  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rd_word,
    output logic [TAP_N*DW-1:0] taps
);
    logic [DW-1:0] mem [DEPTH];

    // One register per word, written when addressed
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                         mem[g] <= '0;
            else if (we && idx == IW'(g))       mem[g] <= wdata;
        end
    end

    // Combinational read of the addressed word
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (idx == IW'(k)) rd_word = mem[k];
        end
    end

    // Export the tap window
    for (genvar t = 0; t < TAP_N; t++) begin : g_tap
        assign taps[t*DW +: DW] = mem[TAP_B + t];
    end

    // A write lands in the addressed word on the next cycle (R3)
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(idx) < DEPTH) |=> (rd_word == $past(wdata) || idx != $past(idx)));
endmodule

// File: rtl/lif_cfg_status.sv
// Module: sticky event status with mask and interrupt. Clear rule is chosen by
// cow (0: read clears all, 1: write-one clears). Events win over clears.
module lif_cfg_status #(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic           cow,
    input  logic           stat_rd,
    input  logic           stat_wr,
    input  logic           mask_wr,
    input  logic [DW-1:0]  wdata,
    output logic [NCH-1:0] stat_q,
    output logic [NCH-1:0] mask_q,
    output logic           irq
);
    logic [NCH-1:0] clr;

    // Bits to clear this cycle under the selected rule
    always_comb begin
        clr = '0;
        if (cow && stat_wr)      clr = wdata[NCH-1:0];
        else if (!cow && stat_rd) clr = '1;
    end

    // Sticky status: clear first, then set by events
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | evt;
    end

    // Mask register, resets fully masked
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= wdata[NCH-1:0];
    end

    // Interrupt from unmasked status
    assign irq = |(stat_q & ~mask_q);

    p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && !stat_wr && evt == '0) |=> $stable(stat_q));
    p_cor_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cow && stat_rd && evt == '0) |=> (stat_q == '0));
    p_cow_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cow && stat_wr && evt == '0) |=> (stat_q == ($past(stat_q) & ~$past(wdata[NCH-1:0]))));
    p_all_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);
endmodule

// File: rtl/lif_cfg_regfile.sv
// Module: top of the banked register file. Holds the bank pointer, clear-mode
// control and registered read data; composes decode, store and status.
// Assumes single-cycle strobes and that read and write are not both high.
module lif_cfg_regfile
    import lif_cfg_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [4:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic [NCH-1:0]   chan_evt,
    output logic             irq,
    output logic [NCH-1:0]   ja_en,
    output logic [NCH-1:0]   ja_deep,
    output logic [NCH-1:0]   ja_trip,
    output logic [NCH-1:0]   scp_off,
    output logic [NCH-1:0]   ais_on_los,
    output logic [NCH-1:0]   rclk_inv,
    output logic [NCH-1:0]   tclk_inv
);
    localparam int TAP_N = CHN_N;

    logic [DATA_W-1:0]       ptr_q;
    logic                    cow_q;
    dec_t                    dec;
    logic [DATA_W-1:0]       store_rd;
    logic [TAP_N*DATA_W-1:0] taps;
    logic [NCH-1:0]          stat_q;
    logic [NCH-1:0]          mask_q;
    logic [DATA_W-1:0]       rd_mux;
    logic                    rsv;

    lif_cfg_decode u_dec (
        .addr (host_addr),
        .ptr  (ptr_q),
        .dec  (dec)
    );

    lif_cfg_store #(
        .DEPTH (STORE_N),
        .DW    (DATA_W),
        .IW    (IDX_W),
        .TAP_B (CHN_B),
        .TAP_N (TAP_N)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (host_wr && dec.hit_store),
        .idx     (dec.idx),
        .wdata   (host_wdata),
        .rd_word (store_rd),
        .taps    (taps)
    );

    lif_cfg_status #(
        .NCH (NCH),
        .DW  (DATA_W)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (chan_evt),
        .cow     (cow_q),
        .stat_rd (host_rd && dec.is_stat),
        .stat_wr (host_wr && dec.is_stat),
        .mask_wr (host_wr && dec.is_mask),
        .wdata   (host_wdata),
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    // Bank pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)                    ptr_q <= PTR_PRI;
        else if (host_wr && dec.is_ptr) ptr_q <= host_wdata;
    end

    // Clear-mode control bit
    always_ff @(posedge clk) begin
        if (!rst_n)                     cow_q <= 1'b0;
        else if (host_wr && dec.is_ictl) cow_q <= host_wdata[0];
    end

    // Select the addressed value; reserved returns zero
    always_comb begin
        rd_mux = '0;
        if (dec.is_ptr)         rd_mux = ptr_q;
        else if (dec.is_stat)   rd_mux = DATA_W'(stat_q);
        else if (dec.is_mask)   rd_mux = DATA_W'(mask_q);
        else if (dec.is_ictl)   rd_mux = {{(DATA_W-1){1'b0}}, cow_q};
        else if (dec.hit_store) rd_mux = store_rd;
    end

    assign rsv = !(dec.is_ptr || dec.is_stat || dec.is_mask || dec.is_ictl || dec.hit_store);

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    // Channel control outputs from the per-channel bank words
    assign ja_en      = taps[0*DATA_W +: NCH];
    assign ja_deep    = taps[1*DATA_W +: NCH];
    assign ja_trip    = taps[2*DATA_W +: NCH];
    assign scp_off    = taps[3*DATA_W +: NCH];
    assign ais_on_los = taps[4*DATA_W +: NCH];
    assign rclk_inv   = taps[5*DATA_W +: NCH];
    assign tclk_inv   = taps[6*DATA_W +: NCH];

    p_rsv_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rsv) |=> (host_rdata == '0));
    p_rdata_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
    p_ptr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == A_PTR) |=> (ptr_q == $past(host_wdata)));
endmodule

// File: tb/lif_cfg_regfile_bench.sv
// Bench: fixed-seed random host traffic plus directed corner cases, checked
// against a behavioural model built from the requirements.
module lif_cfg_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] chan_evt = '0;
    logic       irq;
    logic [7:0] ja_en, ja_deep, ja_trip, scp_off, ais_on_los, rclk_inv, tclk_inv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lif_cfg_regfile u_lif_cfg_regfile (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .chan_evt(chan_evt), .irq(irq), .ja_en(ja_en), .ja_deep(ja_deep),
        .ja_trip(ja_trip), .scp_off(scp_off), .ais_on_los(ais_on_los),
        .rclk_inv(rclk_inv), .tclk_inv(tclk_inv)
    );

    // Model state
    logic [7:0] m_pri [20];
    logic [7:0] m_sec [7];
    logic [7:0] m_chn [8];
    logic [7:0] m_tst [8];
    logic [7:0] m_ptr, m_stat, m_mask;
    logic       m_cow;

    task automatic model_reset();
        for (int i = 0; i < 20; i++) m_pri[i] = 8'h00;
        for (int i = 0; i < 7; i++)  m_sec[i] = 8'h00;
        for (int i = 0; i < 8; i++)  m_chn[i] = 8'h00;
        for (int i = 0; i < 8; i++)  m_tst[i] = 8'h00;
        m_ptr = 8'h00; m_stat = 8'h00; m_mask = 8'hFF; m_cow = 1'b0;
    endtask

    // Kind: 0 reserved, 1 pointer, 2 storage, 3 status, 4 mask, 5 clear control
    function automatic int kind_of(input logic [4:0] a);
        if (a == 5'h1F) return 1;
        case (m_ptr)
            8'h00: begin
                if (a < 5'd20) return 2;
                if (a == 5'h14) return 3;
                if (a == 5'h15) return 4;
            end
            8'hAA: if (a < 5'd7) return 2;
            8'h01: begin
                if (a < 5'd8) return 2;
                if (a == 5'h1E) return 5;
            end
            8'h02: if (a < 5'd8) return 2;
            default: return 0;
        endcase
        return 0;
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        case (kind_of(a))
            1: return m_ptr;
            2: case (m_ptr)
                   8'h00:   return m_pri[a];
                   8'hAA:   return m_sec[a];
                   8'h01:   return m_chn[a];
                   default: return m_tst[a];
               endcase
            3: return m_stat;
            4: return m_mask;
            5: return {7'd0, m_cow};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step(input logic w, input logic r, input logic [4:0] a,
                              input logic [7:0] d, input logic [7:0] ev);
        int k;
        logic [7:0] clr;
        k = kind_of(a);
        clr = 8'h00;
        if (k == 3 && m_cow && w)   clr = d;
        if (k == 3 && !m_cow && r)  clr = 8'hFF;
        m_stat = (m_stat & ~clr) | ev;
        if (w) begin
            case (k)
                1: m_ptr = d;
                2: case (m_ptr)
                       8'h00:   m_pri[a] = d;
                       8'hAA:   m_sec[a] = d;
                       8'h01:   m_chn[a] = d;
                       default: m_tst[a] = d;
                   endcase
                4: m_mask = d;
                5: m_cow = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, one rising edge, check at next falling edge
    task automatic step(input logic w, input logic r, input logic [4:0] a,
                        input logic [7:0] d, input logic [7:0] ev, input string tag);
        logic [7:0] er;
        host_wr = w; host_rd = r; host_addr = a; host_wdata = d; chan_evt = ev;
        er = exp_read(a);
        @(posedge clk);
        model_step(w, r, a, d, ev);
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; chan_evt = 8'h00;
        if (r) chk({tag, " R6 rdata"}, host_rdata, er);
        chk("R11 irq", {7'd0, irq}, {7'd0, |(m_stat & ~m_mask)});
        chk("R5 ja_en", ja_en, m_chn[0]);
        chk("R5 ja_deep", ja_deep, m_chn[1]);
        chk("R5 ja_trip", ja_trip, m_chn[2]);
        chk("R5 scp_off", scp_off, m_chn[3]);
        chk("R5 ais_on_los", ais_on_los, m_chn[4]);
        chk("R5 rclk_inv", rclk_inv, m_chn[5]);
        chk("R5 tclk_inv", tclk_inv, m_chn[6]);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 1'b0, a, d, 8'h00, tag);
    endtask
    task automatic rd(input logic [4:0] a, input string tag);
        step(1'b0, 1'b1, a, 8'h00, 8'h00, tag);
    endtask

    initial begin
        int unsigned seed_dummy;
        logic [7:0] pcodes [5];
        seed_dummy = $urandom(32'd1357);
        model_reset();
        host_rdata_init_wait: begin end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", host_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 ja_en", ja_en, 8'h00);
        rst_n = 1'b1;
        rd(5'h15, "R1 mask");
        rd(5'h1F, "R1 ptr");
        rd(5'h05, "R1 storage");
        // R3: primary storage and bank separation
        wr(5'h05, 8'h5A, "R3");
        wr(5'h13, 8'h3C, "R3");
        rd(5'h05, "R3");
        rd(5'h13, "R3");
        // R4: primary reserved
        wr(5'h17, 8'hEE, "R4");
        rd(5'h17, "R4");
        wr(5'h1F, 8'hAA, "R2");
        rd(5'h1F, "R2");
        wr(5'h05, 8'hC3, "R3 sec");
        rd(5'h05, "R3 sec");
        rd(5'h07, "R4 sec rsv");
        wr(5'h1F, 8'h02, "R2");
        wr(5'h07, 8'h81, "R3 tst");
        rd(5'h07, "R3 tst");
        // R4: undefined pointer
        wr(5'h1F, 8'h55, "R2");
        rd(5'h05, "R4 undef");
        wr(5'h05, 8'h99, "R4 undef");
        rd(5'h1F, "R2 undef");
        // R5: per-channel controls
        wr(5'h1F, 8'h01, "R2");
        for (int i = 0; i < 7; i++) wr(5'(i), 8'(8'h11 * (i + 1)), "R5");
        rd(5'h0A, "R4 chn rsv");
        wr(5'h1F, 8'h00, "R2");
        rd(5'h05, "R3 pri kept");
        // R7/R8/R11: events, mask, clear on read
        step(1'b0, 1'b0, 5'h00, 8'h00, 8'h03, "R7 evt masked");
        wr(5'h15, 8'h00, "R11 unmask");
        step(1'b0, 1'b0, 5'h00, 8'h00, 8'h00, "R7 hold");
        wr(5'h14, 8'hFF, "R8 write ignored");
        rd(5'h14, "R8 read clears");
        rd(5'h14, "R8 now clear");
        // R10: event during read clear
        step(1'b0, 1'b0, 5'h00, 8'h00, 8'h30, "R7");
        step(1'b0, 1'b1, 5'h14, 8'h00, 8'h10, "R10 cor");
        rd(5'h14, "R10 kept");
        // R9: clear on write
        wr(5'h1F, 8'h01, "R2");
        wr(5'h1E, 8'h01, "R9 mode");
        rd(5'h1E, "R9 mode");
        wr(5'h1F, 8'h00, "R2");
        step(1'b0, 1'b0, 5'h00, 8'h00, 8'h0F, "R7");
        rd(5'h14, "R9 read keeps");
        rd(5'h14, "R9 read keeps");
        wr(5'h14, 8'h03, "R9 w1c");
        step(1'b1, 1'b0, 5'h14, 8'h04, 8'h04, "R10 cow");
        rd(5'h14, "R10 cow kept");
        wr(5'h15, 8'hF0, "R11 partial mask");
        wr(5'h14, 8'hFF, "R9 clear all");
        // Random traffic
        pcodes[0] = 8'h00; pcodes[1] = 8'hAA; pcodes[2] = 8'h01; pcodes[3] = 8'h02;
        for (int n = 0; n < 3000; n++) begin
            int unsigned op;
            logic [7:0] ev;
            pcodes[4] = 8'($urandom);
            op = $urandom % 16;
            ev = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            if (op < 2)       step(1'b1, 1'b0, 5'h1F, pcodes[$urandom % 5], ev, "R2 rnd");
            else if (op < 7)  step(1'b1, 1'b0, 5'($urandom), 8'($urandom), ev, "R3 rnd");
            else if (op < 12) step(1'b0, 1'b1, 5'($urandom), 8'h00, ev, "R4 rnd");
            else if (op < 13) step(1'b0, 1'b1, 5'h14, 8'h00, ev, "R8 rnd");
            else if (op < 14) step(1'b1, 1'b0, 5'h14, 8'($urandom), ev, "R9 rnd");
            else if (op < 15) step(1'b1, 1'b0, 5'h1E, 8'($urandom), ev, "R9 rnd");
            else              step(1'b0, 1'b0, 5'h00, 8'h00, ev, "R7 rnd");
        end
        // R1: reset again mid-run
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        chk("R1 rdata", host_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 tclk_inv", tclk_inv, 8'h00);
        rst_n = 1'b1;
        rd(5'h15, "R1 mask");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule